// File: doc/BRIEF.md
# Mode-Configurable Single-Byte SPI Master

This block is a bus master for one SPI byte exchange. A one-cycle start strobe launches a frame. The block then shifts the transmit byte out on MOSI, most significant bit first, and shifts a byte in from MISO. Clock polarity, clock phase and a clock divider are inputs. All three are captured when the frame begins, so they can change freely while a frame is running.

The frame start has a fixed order. The first data bit goes onto MOSI while the active-low slave select is still high. Slave select falls one half SCLK period later. The first SCLK edge comes one further half period after that. So MOSI is valid before the frame opens, and it is valid for a full setup interval before the first edge, in every mode.

After the eighth SCLK cycle the clock returns to its idle level. Slave select rises one half period after the last edge. In that same cycle a one-cycle done pulse marks the received byte as valid. The block then accepts a new start.

Top module: `spi_mode_master`

## Requirements
- R1: While idle, and during reset, `sclk` equals the live `cpol` input. During reset and while idle, `ss_n` is 1, `mosi` is 0, and `busy` and `done` are 0.
- R2: One half SCLK period is `div+1` system clock cycles. Each frame makes exactly 16 SCLK edges (8 cycles), spaced one half period apart.
- R3: `busy` rises in the cycle after an accepted start. In that first busy cycle, `mosi` already carries `tx_data[7]` and `ss_n` is still 1. `ss_n` falls one half period later, and `mosi` is unchanged at that point.
- R4: The first SCLK edge follows the fall of `ss_n` by one half period.
- R5: Bits leave MSB first. With `cpha`=0, MOSI changes on trailing edges (edges 2, 4, …, 14, counted from 1). With `cpha`=1, MOSI changes on leading edges 3, 5, …, 15. A slave that samples on the opposite edge therefore receives `tx_data` unchanged. For example, 0x01 appears as seven zeros and then a one.
- R6: MISO is captured on the leading edges (odd edges) when `cpha`=0, and on the trailing edges (even edges) when `cpha`=1. The first captured bit becomes `rx_data[7]`.
- R7: `ss_n` rises one half period after the 16th edge. In that same cycle `done` is 1 for exactly one cycle, `busy` is 0, and `rx_data` holds the received byte.
- R8: A start strobe that arrives while `busy` is 1 is ignored. The running frame completes with its original data, and no second frame follows.
- R9: `cpol`, `cpha` and `div` are captured at the accepted start. Changing them during a frame does not alter that frame's timing, edges or data.
- R10: In the cycle `done` is 1, `sclk` is back at the `cpol` level and `mosi` has returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| tx_data | input | 8 | Byte to transmit, captured at start |
| cpol | input | 1 | Idle SCLK level |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| div | input | 8 | Half-period length minus one, in system clocks |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| rx_data | output | 8 | Last received byte, valid when done pulses |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Take H as `div+1` and count from the first cycle in which `busy` is high. On that schedule, `ss_n` falls at H, SCLK edge k (counted from 1) occurs at (1+k)·H, and `ss_n` rises together with `done` at 18·H. The monitor samples on the falling system clock edge and measures each interval between observed changes against H, so every result is checked in exactly the cycle it is due. A behavioural slave in the bench changes MISO and records MOSI on the edges the requirements give for each phase. Its recorded byte, and the design's `rx_data`, are compared with the scoreboard entry at the done cycle.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LEAD,
    ST_EDGES,
    ST_TAIL
  } seq_state_t;

  // Edge index counts from 0; even indices are leading edges.
  function automatic logic edge_samples(input logic cpha, input logic [31:0] idx);
    return (idx[0] == cpha);
  endfunction

  function automatic logic edge_shifts(input logic cpha, input logic [31:0] idx,
                                       input logic [31:0] bits);
    if (cpha)
      return (idx[0] == 1'b0) && (idx >= 32'd2);
    else
      return (idx[0] == 1'b1) && (idx < (2 * bits - 1));
  endfunction

endpackage

// File: rtl/spi_mm_tick.sv
module spi_mm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart || tick || !run)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_mm_seq.sv
module spi_mm_seq
  import spi_mm_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cpha,
  input  logic tick,
  output logic busy,
  output logic load,
  output logic ss_n,
  output logic phase,
  output logic done,
  output logic finish,
  output logic sample_en,
  output logic shift_en
);

  localparam int EDGES = 2 * BITS;
  localparam int IDX_W = $clog2(EDGES);
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(EDGES - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] edge_cnt;
  logic             edge_fire;

  assign busy      = (state != ST_IDLE);
  assign load      = start && (state == ST_IDLE);
  assign edge_fire = tick && ((state == ST_LEAD) || (state == ST_EDGES));
  assign finish    = tick && (state == ST_TAIL);
  assign sample_en = edge_fire && edge_samples(cpha, 32'(edge_cnt));
  assign shift_en  = edge_fire && edge_shifts(cpha, 32'(edge_cnt), 32'(BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      ss_n     <= 1'b1;
      phase    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_PRE;
            edge_cnt <= '0;
            phase    <= 1'b0;
          end
        end
        ST_PRE: begin
          if (tick) begin
            state <= ST_LEAD;
            ss_n  <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            state    <= ST_EDGES;
            phase    <= ~phase;
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        ST_EDGES: begin
          if (tick) begin
            phase <= ~phase;
            if (edge_cnt == LAST_EDGE)
              state <= ST_TAIL;
            else
              edge_cnt <= edge_cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state <= ST_IDLE;
            ss_n  <= 1'b1;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SS_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> busy); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_EDGE_NEEDS_SS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> !ss_n); // R2

  AST_PHASE_HOME_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> !phase); // R10

endmodule

// File: rtl/spi_mm_shift.sv
module spi_mm_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] tx,
  input  logic            shift_en,
  input  logic            sample_en,
  input  logic            finish,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rx_data
);

  logic [BITS-1:0] tx_sr;
  logic [BITS-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      mosi    <= 1'b0;
      rx_data <= '0;
    end else begin
      if (load) begin
        tx_sr <= tx;
        mosi  <= tx[BITS-1];
      end else if (shift_en) begin
        tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        mosi  <= tx_sr[BITS-2];
      end else if (finish) begin
        mosi <= 1'b0;
      end
      if (sample_en)
        rx_sr <= {rx_sr[BITS-2:0], miso};
      if (finish)
        rx_data <= rx_sr;
    end
  end

  AST_SAMPLE_APART_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_en && shift_en)); // R5

  AST_MOSI_HELD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> $stable(mosi)); // R6

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mm_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BITS-1:0]  tx_data,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             ss_n,
  output logic [BITS-1:0]  rx_data,
  output logic             busy,
  output logic             done
);

  logic             cpol_q;
  logic             cpha_q;
  logic [DIV_W-1:0] div_q;
  logic             load;
  logic             tick;
  logic             phase;
  logic             finish;
  logic             sample_en;
  logic             shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      div_q  <= '0;
    end else if (load) begin
      cpol_q <= cpol;
      cpha_q <= cpha;
      div_q  <= div;
    end
  end

  assign sclk = phase ^ (busy ? cpol_q : cpol);

  spi_mm_tick #(.DIV_W(DIV_W)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .restart(load),
    .div    (div_q),
    .tick   (tick)
  );

  spi_mm_seq #(.BITS(BITS)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cpha     (cpha_q),
    .tick     (tick),
    .busy     (busy),
    .load     (load),
    .ss_n     (ss_n),
    .phase    (phase),
    .done     (done),
    .finish   (finish),
    .sample_en(sample_en),
    .shift_en (shift_en)
  );

  spi_mm_shift #(.BITS(BITS)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .tx       (tx_data),
    .shift_en (shift_en),
    .sample_en(sample_en),
    .finish   (finish),
    .miso     (miso),
    .mosi     (mosi),
    .rx_data  (rx_data)
  );

  AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol)); // R1

  AST_MOSI_BEFORE_SS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $stable(mosi)); // R3

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !load); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cpha_q) && $stable(div_q))); // R9

endmodule

// File: tb/spi_mode_master_tb_top.sv
module spi_mode_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_data = '0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [7:0] div = '0;
  logic       miso = 1'b0;
  logic       sclk, mosi, ss_n, busy, done;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  spi_mode_master dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
    .cpol(cpol), .cpha(cpha), .div(div), .miso(miso),
    .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .rx_data(rx_data),
    .busy(busy), .done(done)
  );

  typedef struct {
    logic [7:0] tx;
    logic [7:0] slv;
    logic       cpha;
    int         h;
  } xfer_t;

  xfer_t sbq[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] s_byte = '0;
  logic       s_cpha = 1'b0;
  logic [7:0] s_rx = '0;
  int         s_edges = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural slave: drives MISO and captures MOSI per phase rules.
  always begin
    logic [7:0] sh;
    logic [7:0] rcv;
    logic       lead;
    int         n;
    @(negedge ss_n);
    sh = s_byte;
    rcv = '0;
    miso = sh[7];
    n = 0;
    while (n < 16 && !ss_n) begin
      @(sclk or posedge ss_n);
      if (ss_n) break;
      n++;
      lead = (n % 2) == 1;
      if (lead != s_cpha)
        rcv = {rcv[6:0], mosi};
      else if (n >= 2 && n < 16) begin
        sh = {sh[6:0], 1'b0};
        miso = sh[7];
      end
    end
    s_rx = rcv;
    s_edges = n;
  end

  // Monitor: pops the scoreboard when a frame opens and times every event.
  initial begin
    xfer_t it;
    int    t;
    logic  prev;
    forever begin
      @(negedge clk);
      if (!rst_n || !busy) continue;
      if (sbq.size() == 0) begin
        check("R8", "unexpected frame", 1, 0);
        while (busy) @(negedge clk);
        continue;
      end
      it = sbq.pop_front();
      check("R3", "mosi at busy rise", int'(mosi), int'(it.tx[7]));
      check("R3", "ss_n at busy rise", int'(ss_n), 1);
      t = cyc;
      while (ss_n) @(negedge clk);
      check("R3", "busy to ss_n fall", cyc - t, it.h);
      check("R3", "mosi at ss_n fall", int'(mosi), int'(it.tx[7]));
      t = cyc;
      prev = sclk;
      for (int e = 0; e < 16; e++) begin
        while (sclk == prev && !ss_n) @(negedge clk);
        if (e == 0) check("R4", "ss_n fall to first edge", cyc - t, it.h);
        else check("R2", "edge spacing", cyc - t, it.h);
        prev = sclk;
        t = cyc;
      end
      while (!ss_n) @(negedge clk);
      check("R7", "last edge to ss_n rise", cyc - t, it.h);
      check("R7", "done with ss_n rise", int'(done), 1);
      check("R7", "busy low at done", int'(busy), 0);
      check("R6", "rx_data", int'(rx_data), int'(it.slv));
      check("R5", "slave received", int'(s_rx), int'(it.tx));
      check("R2", "edge count", s_edges, 16);
      check("R10", "sclk idle level", int'(sclk), int'(cpol));
      check("R10", "mosi back low", int'(mosi), 0);
      @(negedge clk);
      check("R7", "done width", int'(done), 0);
    end
  end

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input logic cp,
                      input logic ch, input logic [7:0] dv, input bit disturb);
    xfer_t it;
    @(negedge clk);
    cpol = cp; cpha = ch; div = dv; tx_data = tx;
    s_byte = slv; s_cpha = ch;
    it.tx = tx; it.slv = slv; it.cpha = ch; it.h = int'(dv) + 1;
    sbq.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R8 and R9: a second start with different data and settings mid-frame.
      repeat (3 * (int'(dv) + 1) + 2) @(negedge clk);
      start = 1'b1; tx_data = ~tx; cpol = ~cp; cpha = ~ch; div = dv + 8'd2;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (disturb) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R8", "no frame after ignored start", int'(busy), 0);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset sclk cpol=1", int'(sclk), 1);
    check("R1", "reset ss_n", int'(ss_n), 1);
    check("R1", "reset mosi", int'(mosi), 0);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset done", int'(done), 0);
    cpol = 1'b0;
    @(negedge clk);
    check("R1", "reset sclk cpol=0", int'(sclk), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "idle ss_n", int'(ss_n), 1);

    xfer(8'h01, 8'hA5, 1'b0, 1'b0, 8'd1, 1'b0);
    xfer(8'hC3, 8'h3C, 1'b0, 1'b1, 8'd0, 1'b0);
    xfer(8'h5A, 8'h81, 1'b1, 1'b0, 8'd2, 1'b0);
    xfer(8'hFF, 8'h00, 1'b1, 1'b1, 8'd3, 1'b0);
    xfer(8'h80, 8'h7E, 1'b0, 1'b0, 8'd0, 1'b0);
    xfer(8'h96, 8'h69, 1'b1, 1'b1, 8'd1, 1'b1);
    xfer(8'h3E, 8'hD2, 1'b0, 1'b1, 8'd0, 1'b1);

    repeat (4) @(negedge clk);
    check("R8", "scoreboard drained", sbq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule